// File: doc/BRIEF.md
# Weighted Singleton Defuzzifier

This block is the final stage of a fuzzy inference pipeline. It receives, one per rule, a crisp singleton position (8 bits) and the firing weight of that rule (4 bits). For the output variable being built, it keeps two sums side by side: the weights, and the positions multiplied by their weights. When upstream marks a rule as the last one of the variable, a bit-serial divider forms the quotient. That quotient is the weighted average of the singleton positions, and it is the crisp output.

An elaboration starts with a single `start` pulse, which also gives the number of output variables minus one. The variables are built one after another. Each finished result is released on the output bus with a strobe and a 2-bit index. The strobe lasts several cycles for intermediate variables and one cycle for the last. A downstream consumer can raise `wait_in` to stall the release. The result is still computed, but it is not put on the bus until the wait is removed. `busy` covers the whole elaboration. A variable whose weights all sum to zero produces 0 and a one-cycle error pulse.

Top module: `singleton_defuzzifier`

## Requirements
- R1: After synchronous reset, `busy`, `out_strobe` and `err` are 0, and `out_data` and `out_id` are 0.
- R2: A `start` pulse taken while idle raises `busy` in the following cycle. The elaboration delivers exactly `out_cnt_m1`+1 results. A `start` pulse taken while busy is ignored.
- R3: Each result equals floor(sum(pos*wt) / sum(wt)) over the rules accepted for that variable. A rule is accepted on a cycle with `rule_valid`=1 during accumulation. The rule with `rule_last`=1 closes the variable. The sums cannot overflow for up to 256 rules of full-scale value (pos 255, weight 15).
- R4: If the weight sum of a variable is zero, its result is 0. `err` is high for exactly one cycle before that result's strobe.
- R5: Results appear in order with `out_id` = 0, 1, 2, ... Both sums are cleared before each new variable.
- R6: `out_strobe` stays high for 5 consecutive cycles for every result except the last of an elaboration, which gets 1 cycle. `out_data` and `out_id` stay stable during the strobe and keep their value after it.
- R7: A strobe never starts in the cycle after `wait_in` was sampled high. A result finished during a wait is held back and released once `wait_in` is low.
- R8: `busy` stays high from the cycle after `start` until the last strobe ends, and falls in the same cycle that strobe ends.
- R9: Rules presented while the block is idle, dividing or presenting a result do not change any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an elaboration (taken only when idle) |
| out_cnt_m1 | input | 2 | Number of output variables minus one, sampled with `start` |
| rule_valid | input | 1 | A rule result is present on `rule_pos`/`rule_wt` |
| rule_pos | input | 8 | Singleton abscissa of the rule consequent |
| rule_wt | input | 4 | Firing weight of the rule |
| rule_last | input | 1 | This rule closes the current output variable |
| wait_in | input | 1 | Hold back release of the next result |
| busy | output | 1 | Elaboration in progress |
| out_strobe | output | 1 | A new result is on `out_data` |
| out_data | output | 8 | Crisp output value |
| out_id | output | 2 | Index of the output variable on `out_data` |
| err | output | 1 | One-cycle pulse: zero weight sum met |

## Verification
The bound checker watches several properties on every cycle:
- strobe lengths of 5 or 1 cycles, with the short one at the end of busy;
- data and index held steady during a strobe;
- no strobe rising after a sampled wait;
- single-cycle error pulses that occur only while busy.

Other properties can only be shown by the bench's scenarios, which compare each result against sums it keeps itself:
- the numeric value of each weighted average;
- the index order;
- the clearing of the sums between variables;
- the full-scale 256-rule case;
- the rejection of rules and restart pulses that arrive outside accumulation.

// File: rtl/dfz_pkg.sv
package dfz_pkg;

    parameter int POS_W       = 8;
    parameter int WT_W        = 4;
    parameter int MAX_RULES   = 256;
    parameter int MAX_OUTS    = 4;
    parameter int MID_STROBE  = 5;
    parameter int LAST_STROBE = 1;

    localparam int RCNT_W = $clog2(MAX_RULES);
    localparam int PROD_W = POS_W + WT_W;
    localparam int NUM_W  = PROD_W + RCNT_W;
    localparam int DEN_W  = WT_W + RCNT_W;
    localparam int ID_W   = $clog2(MAX_OUTS);
    localparam int DCNT_W = $clog2(POS_W + 1);
    localparam int STB_MAX = (MID_STROBE > LAST_STROBE) ? MID_STROBE : LAST_STROBE;
    localparam int STB_W  = $clog2(STB_MAX + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACC,
        ST_DIV_GO,
        ST_DIV_RUN,
        ST_PRESENT,
        ST_STROBE
    } dfz_state_e;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [WT_W-1:0]  wt;
    } dfz_rule_t;

    typedef struct packed {
        logic [DEN_W-1:0] rem;
        logic             qbit;
    } dfz_step_t;

    // One restoring step: shift a numerator bit into the remainder and
    // subtract the divisor when it fits.
    function automatic dfz_step_t div_step(input logic [DEN_W-1:0] rem,
                                           input logic             nbit,
                                           input logic [DEN_W-1:0] den);
        dfz_step_t        r;
        logic [DEN_W:0]   trial;
        logic [DEN_W:0]   diff;
        trial = {rem, nbit};
        diff  = trial - {1'b0, den};
        if (trial >= {1'b0, den}) begin
            r.rem  = diff[DEN_W-1:0];
            r.qbit = 1'b1;
        end else begin
            r.rem  = trial[DEN_W-1:0];
            r.qbit = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/dfz_accum.sv
module dfz_accum
    import dfz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  dfz_rule_t        rule,
    output logic [NUM_W-1:0] num_o,
    output logic [DEN_W-1:0] den_o
);

    logic [PROD_W-1:0] prod;

    assign prod = PROD_W'(rule.pos) * PROD_W'(rule.wt);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            num_o <= '0;
            den_o <= '0;
        end else if (en) begin
            num_o <= num_o + NUM_W'(prod);
            den_o <= den_o + DEN_W'(rule.wt);
        end
    end

endmodule

// File: rtl/dfz_divider.sv
module dfz_divider
    import dfz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [POS_W-1:0] quot
);

    logic [DEN_W-1:0]  rem;
    logic [DEN_W-1:0]  den_q;
    logic [POS_W-1:0]  nlo;
    logic [DCNT_W-1:0] cnt;
    dfz_step_t         step;

    assign step = div_step(rem, nlo[POS_W-1], den_q);

    // The high numerator part is below the divisor (average fits POS_W bits),
    // so it seeds the remainder and POS_W steps finish the quotient.
    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            den_q <= '0;
            nlo   <= '0;
            cnt   <= '0;
            quot  <= '0;
            done  <= 1'b0;
        end else if (go) begin
            rem   <= num[NUM_W-1:POS_W];
            nlo   <= num[POS_W-1:0];
            den_q <= den;
            cnt   <= DCNT_W'(POS_W);
            quot  <= '0;
            done  <= 1'b0;
        end else if (cnt != '0) begin
            rem   <= step.rem;
            nlo   <= {nlo[POS_W-2:0], 1'b0};
            quot  <= {quot[POS_W-2:0], step.qbit};
            cnt   <= cnt - 1'b1;
            done  <= (cnt == DCNT_W'(1));
        end else begin
            done  <= 1'b0;
        end
    end

endmodule

// File: rtl/dfz_pulse_timer.sv
module dfz_pulse_timer
    import dfz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [STB_W-1:0] load_val,
    input  logic             dec,
    output logic             expire
);

    logic [STB_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == STB_W'(1));

endmodule

// File: rtl/singleton_defuzzifier.sv
module singleton_defuzzifier
    import dfz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ID_W-1:0]  out_cnt_m1,
    input  logic             rule_valid,
    input  logic [POS_W-1:0] rule_pos,
    input  logic [WT_W-1:0]  rule_wt,
    input  logic             rule_last,
    input  logic             wait_in,
    output logic             busy,
    output logic             out_strobe,
    output logic [POS_W-1:0] out_data,
    output logic [ID_W-1:0]  out_id,
    output logic             err
);

    dfz_state_e       state;
    logic [ID_W-1:0]  cur_id;
    logic [ID_W-1:0]  last_id;
    logic [POS_W-1:0] res;
    logic [NUM_W-1:0] num;
    logic [DEN_W-1:0] den;
    logic [POS_W-1:0] div_q;
    logic             div_done;
    logic             div_go;
    logic             acc_en;
    logic             acc_clr;
    logic             tmr_load;
    logic             tmr_expire;
    logic [STB_W-1:0] tmr_val;
    logic             on_last;
    dfz_rule_t        rule_in;

    assign rule_in  = '{pos: rule_pos, wt: rule_wt};
    assign on_last  = (cur_id == last_id);
    assign acc_en   = (state == ST_ACC) && rule_valid;
    assign acc_clr  = ((state == ST_IDLE) && start) ||
                      ((state == ST_STROBE) && tmr_expire);
    assign div_go   = (state == ST_DIV_GO) && (den != '0);
    assign tmr_load = (state == ST_PRESENT) && !wait_in;
    assign tmr_val  = on_last ? STB_W'(LAST_STROBE) : STB_W'(MID_STROBE);

    assign busy       = (state != ST_IDLE);
    assign out_strobe = (state == ST_STROBE);

    dfz_accum u_accum (
        .clk   (clk),
        .rst   (rst),
        .clr   (acc_clr),
        .en    (acc_en),
        .rule  (rule_in),
        .num_o (num),
        .den_o (den)
    );

    dfz_divider u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (num),
        .den  (den),
        .done (div_done),
        .quot (div_q)
    );

    dfz_pulse_timer u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (out_strobe),
        .expire   (tmr_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_id   <= '0;
            last_id  <= '0;
            res      <= '0;
            out_data <= '0;
            out_id   <= '0;
            err      <= 1'b0;
        end else begin
            err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_id  <= '0;
                        last_id <= out_cnt_m1;
                        state   <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    if (rule_valid && rule_last) state <= ST_DIV_GO;
                end
                ST_DIV_GO: begin
                    if (den == '0) begin
                        res   <= '0;
                        err   <= 1'b1;
                        state <= ST_PRESENT;
                    end else begin
                        state <= ST_DIV_RUN;
                    end
                end
                ST_DIV_RUN: begin
                    if (div_done) begin
                        res   <= div_q;
                        state <= ST_PRESENT;
                    end
                end
                ST_PRESENT: begin
                    if (!wait_in) begin
                        out_data <= res;
                        out_id   <= cur_id;
                        state    <= ST_STROBE;
                    end
                end
                ST_STROBE: begin
                    if (tmr_expire) begin
                        if (on_last) begin
                            state <= ST_IDLE;
                        end else begin
                            cur_id <= cur_id + 1'b1;
                            state  <= ST_ACC;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dfz_checker.sv
module dfz_checker
    import dfz_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wait_in,
    input logic             busy,
    input logic             out_strobe,
    input logic [POS_W-1:0] out_data,
    input logic [ID_W-1:0]  out_id,
    input logic             err
);

    logic [STB_W:0] len_q;

    always_ff @(posedge clk) begin
        if (rst)             len_q <= '0;
        else if (out_strobe) len_q <= len_q + 1'b1;
        else                 len_q <= '0;
    end

    AST_STROBE_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(out_strobe) |-> !$past(wait_in)); // R7

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (!out_strobe && $past(out_strobe)) |->
            (len_q == (STB_W+1)'(MID_STROBE) || len_q == (STB_W+1)'(LAST_STROBE))); // R6

    AST_LAST_STROBE_SHORT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(out_strobe) && len_q == (STB_W+1)'(LAST_STROBE))); // R8

    AST_STROBE_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
        (out_strobe && $past(out_strobe)) |-> ($stable(out_data) && $stable(out_id))); // R6

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        out_strobe |-> busy); // R8

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        err |=> !err); // R4

    AST_ERR_NOT_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        err |-> (busy && !out_strobe)); // R4

endmodule

bind singleton_defuzzifier dfz_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wait_in    (wait_in),
    .busy       (busy),
    .out_strobe (out_strobe),
    .out_data   (out_data),
    .out_id     (out_id),
    .err        (err)
);

// File: tb/singleton_defuzzifier_test.sv
module singleton_defuzzifier_test;
    import dfz_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [ID_W-1:0]  out_cnt_m1 = '0;
    logic             rule_valid = 1'b0;
    logic [POS_W-1:0] rule_pos = '0;
    logic [WT_W-1:0]  rule_wt = '0;
    logic             rule_last = 1'b0;
    logic             wait_in = 1'b0;
    logic             busy;
    logic             out_strobe;
    logic [POS_W-1:0] out_data;
    logic [ID_W-1:0]  out_id;
    logic             err;

    int n_chk  = 0;
    int n_fail = 0;
    int err_cnt = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    singleton_defuzzifier uut (
        .clk(clk), .rst(rst), .start(start), .out_cnt_m1(out_cnt_m1),
        .rule_valid(rule_valid), .rule_pos(rule_pos), .rule_wt(rule_wt),
        .rule_last(rule_last), .wait_in(wait_in), .busy(busy),
        .out_strobe(out_strobe), .out_data(out_data), .out_id(out_id), .err(err)
    );

    always @(negedge clk) if (err) err_cnt++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int expect_avg(input int num, input int den);
        return (den == 0) ? 0 : num / den;
    endfunction

    // mode: bit0 hold wait, bit1 junk rules outside accumulation, bit2 restart pulse while busy
    // kind: 0 random, 1 zero weights in variable 0, 2 full-scale 256 rules
    task automatic run_elab(input int n_out, input int mode, input int kind);
        int num, den, nr, expv, width, t, ebase;
        logic [POS_W-1:0] d0;
        logic [ID_W-1:0]  i0;
        @(negedge clk);
        start = 1'b1;
        out_cnt_m1 = ID_W'(n_out - 1);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        for (int o = 0; o < n_out; o++) begin
            num = 0;
            den = 0;
            ebase = err_cnt;
            nr = (kind == 2) ? MAX_RULES : 2 + int'($urandom % 10);
            if (mode[0]) wait_in = 1'b1;
            for (int r = 0; r < nr; r++) begin
                int p, w;
                p = int'($urandom % 256);
                w = int'($urandom % 16);
                if (kind == 1 && o == 0) w = 0;
                if (kind == 2) begin p = 255; w = 15; end
                num += p * w;
                den += w;
                rule_valid = 1'b1;
                rule_pos   = POS_W'(p);
                rule_wt    = WT_W'(w);
                rule_last  = (r == nr - 1);
                if (mode[2] && o == 0 && r == 0) begin
                    start = 1'b1;
                    out_cnt_m1 = ID_W'(n_out % MAX_OUTS);
                end
                @(negedge clk);
                start = 1'b0;
            end
            rule_valid = 1'b0;
            rule_last  = 1'b0;
            if (mode[1]) begin
                rule_valid = 1'b1;
                rule_pos   = 8'd255;
                rule_wt    = 4'd15;
                rule_last  = 1'b1;
            end
            if (mode[0]) begin
                int seen;
                seen = 0;
                repeat (40) begin
                    @(negedge clk);
                    if (out_strobe) seen++;
                end
                chk(seen == 0, "R7 no strobe while wait high", seen, 0);
                wait_in = 1'b0;
            end
            t = 0;
            while (!out_strobe && t < 1000) begin
                @(negedge clk);
                t++;
            end
            rule_valid = 1'b0;
            rule_last  = 1'b0;
            expv = expect_avg(num, den);
            chk(out_strobe == 1'b1, "R7 result released", out_strobe, 1);
            chk(int'(out_data) == expv, "R3 weighted average", out_data, expv);
            chk(int'(out_id) == o, "R5 output index", out_id, o);
            chk(err_cnt - ebase == ((den == 0) ? 1 : 0), "R4 error pulse count",
                err_cnt - ebase, (den == 0) ? 1 : 0);
            d0 = out_data;
            i0 = out_id;
            width = 0;
            while (out_strobe && width < 100) begin
                if (out_data != d0 || out_id != i0) chk(1'b0, "R6 stable in strobe", out_data, d0);
                width++;
                @(negedge clk);
            end
            chk(width == ((o == n_out - 1) ? LAST_STROBE : MID_STROBE), "R6 strobe width",
                width, (o == n_out - 1) ? LAST_STROBE : MID_STROBE);
            chk(out_data == d0, "R6 data held after strobe", out_data, d0);
            if (o == n_out - 1) chk(busy == 1'b0, "R8 busy falls with last strobe", busy, 0);
            else                chk(busy == 1'b1, "R8 busy between outputs", busy, 1);
        end
        repeat (12) @(negedge clk);
        chk(!busy && !out_strobe, "R2 no extra output", busy, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !out_strobe && !err, "R1 reset flags", {busy, out_strobe, err}, 0);
        chk(out_data == '0 && out_id == '0, "R1 reset data", out_data, 0);

        // R9: rules while idle must not leak into the next elaboration
        rule_valid = 1'b1; rule_pos = 8'd200; rule_wt = 4'd15; rule_last = 1'b1;
        repeat (4) @(negedge clk);
        rule_valid = 1'b0; rule_last = 1'b0;
        chk(!busy, "R9 idle rule ignored", busy, 0);

        // directed: 10*3 + 20*1 = 50, /4 -> 12
        @(negedge clk);
        start = 1'b1; out_cnt_m1 = '0;
        @(negedge clk);
        start = 1'b0;
        rule_valid = 1'b1; rule_pos = 8'd10; rule_wt = 4'd3; rule_last = 1'b0;
        @(negedge clk);
        rule_pos = 8'd20; rule_wt = 4'd1; rule_last = 1'b1;
        @(negedge clk);
        rule_valid = 1'b0; rule_last = 1'b0;
        while (!out_strobe) @(negedge clk);
        chk(out_data == 8'd12, "R3 directed average", out_data, 12);
        chk(out_id == '0, "R5 single output index", out_id, 0);
        @(negedge clk);
        chk(!out_strobe && !busy, "R6 last strobe one cycle", out_strobe, 0);

        run_elab(2, 0, 1);   // R4 zero weights
        run_elab(1, 0, 2);   // R3 full-scale capacity
        run_elab(4, 3, 0);   // R7 and R9
        run_elab(3, 4, 0);   // R2 restart ignored
        for (int k = 0; k < 14; k++)
            run_elab(1 + int'($urandom % 4), int'($urandom % 8), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule